// File: doc/BRIEF.md
# GPIO Interrupt Sense and Status Controller

This block watches 32 already-synchronised GPIO input pins and turns selected transitions or levels on them into latched interrupt events. Each pin has its own 4-bit detection code. The code picks one of five detection modes: rising edge, falling edge, both edges, high level or low level. Any other code value disables detection on that pin. A pin records a detected event only while its accept-enable bit is set. Recorded events stay latched until software acknowledges them.

Software reaches the block through a simple write strobe with a byte address and 32-bit data. Reads are combinational from the address. The mask-enable vector is changed through two write-1 registers, one that sets bits and one that clears them. The latched events, ANDed with that mask, drive two interrupt lines. One line covers the lower half of the pins and the other covers the upper half. The detection codes sit in a second bank of four registers, with eight pins in each register.

The detector in each pin evaluates its mode as a small set of named conditions. NONE means the code is not recognised. RISE, FALL and BOTH compare the pin with its value in the previous cycle. HIGH and LOW look at the current value only. From these conditions the event bit takes one of three transitions on each clock: SET, CLEAR or HOLD.

Top module: `gpio_irq_sense_ctrl`

## Requirements
- R1: After reset, every register reads 0, no event is latched, and both interrupt outputs are low.
- R2: Code 8 latches an event on a 0-to-1 change of the pin between consecutive cycles. Code 9 latches an event on a 1-to-0 change. The event bit is readable on the clock edge that samples the change.
- R3: Code 10 latches an event in every cycle where the pin is 1. Code 11 latches an event in every cycle where the pin is 0.
- R4: Code 12 latches an event on either change of the pin. Codes 0 to 7 and 13 to 15 never latch an event.
- R5: The vector at byte offset 0x14 can be read and written, with bit p for pin p. While bit p is 0, pin p latches no new event, and an event it already holds is kept.
- R6: A write to 0x18 sets the mask-enable bits where the data is 1. A write to 0x1C clears the mask-enable bits where the data is 1. A read of 0x1C returns the mask-enable vector. Bits written as 0 are left unchanged.
- R7: A read of 0x20 returns the latched event vector. A read of 0x24 returns that vector ANDed with the mask-enable vector.
- R8: A write to 0x28 clears the latched event bits where the data is 1 and leaves the other bits as they are. This works whatever the value of the accept-enable vector.
- R9: irq_lo is 1 exactly when some pin from 0 to 15 has a masked pending event. irq_hi is 1 exactly when some pin from 16 to 31 has one.
- R10: When an accepted edge and an acknowledge of the same pin fall in the same cycle, the event bit stays 1.
- R11: In a level mode, an acknowledge clears the bit for one cycle. The bit is set again on the next clock while the level still holds.
- R12: Pin p's code sits in register 0x40+4*(p/8), in bits 4*(p%8)+3 down to 4*(p%8). The previous-value register follows the pin during reset, so a pin that is held constant across reset release produces no edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | 32 | Synchronised GPIO pin levels |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 7 | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr |
| irq_lo | output | 1 | Interrupt for pins 0 to 15 |
| irq_hi | output | 1 | Interrupt for pins 16 to 31 |

## Verification
An acknowledge write and a fresh detection on the same pin can land in the same clock cycle. The bench provokes this in two ways. First, it raises a pin configured for rising edges in the same cycle as the strobe that acknowledges that pin. Second, it acknowledges a pin held in a high-level mode. In the edge case, the event bit must read 1 right after the write. In the level case, it must read 0 right after the write and 1 one cycle later.

// File: rtl/gis_pkg.sv
package gis_pkg;
    localparam int ADDR_W  = 7;
    localparam int FIELD_W = 4;

    localparam logic [ADDR_W-1:0] OFF_ACCEPT = 7'h14;
    localparam logic [ADDR_W-1:0] OFF_MSET   = 7'h18;
    localparam logic [ADDR_W-1:0] OFF_MCLR   = 7'h1C;
    localparam logic [ADDR_W-1:0] OFF_RAW    = 7'h20;
    localparam logic [ADDR_W-1:0] OFF_MSTAT  = 7'h24;
    localparam logic [ADDR_W-1:0] OFF_ACK    = 7'h28;
    localparam logic [ADDR_W-1:0] OFF_SENSE  = 7'h40;

    typedef enum logic [FIELD_W-1:0] {
        SN_RISE = 4'd8,
        SN_FALL = 4'd9,
        SN_HIGH = 4'd10,
        SN_LOW  = 4'd11,
        SN_BOTH = 4'd12
    } sense_e;

    typedef enum logic [1:0] {
        EV_HOLD,
        EV_SET,
        EV_CLEAR
    } ev_step_e;
endpackage

// File: rtl/gis_pin_cell.sv
module gis_pin_cell
    import gis_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pin,
    input  logic [FIELD_W-1:0] mode,
    input  logic               accept,
    input  logic               ack,
    output logic               event_q
);
    logic     prev_q;
    logic     edge_hit;
    logic     lvl_hit;
    ev_step_e step;

    // Previous value follows the pin at all times, reset included,
    // so the first compared cycle after reset sees no false edge.
    always_ff @(posedge clk) begin
        prev_q <= pin;
    end

    always_comb begin
        edge_hit = 1'b0;
        lvl_hit  = 1'b0;
        unique case (mode)
            SN_RISE: edge_hit = pin & ~prev_q;
            SN_FALL: edge_hit = ~pin & prev_q;
            SN_BOTH: edge_hit = pin ^ prev_q;
            SN_HIGH: lvl_hit  = pin;
            SN_LOW:  lvl_hit  = ~pin;
            default: ;
        endcase
    end

    // Accepted edge beats acknowledge; acknowledge beats a level hit.
    always_comb begin
        if (accept && edge_hit) begin
            step = EV_SET;
        end else if (ack) begin
            step = EV_CLEAR;
        end else if (accept && lvl_hit) begin
            step = EV_SET;
        end else begin
            step = EV_HOLD;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            event_q <= 1'b0;
        end else begin
            unique case (step)
                EV_SET:   event_q <= 1'b1;
                EV_CLEAR: event_q <= 1'b0;
                default:  event_q <= event_q;
            endcase
        end
    end

    p_edge_beats_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && edge_hit) |=> event_q);

    p_ack_drops_level_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !(accept && edge_hit)) |=> !event_q);

    p_blocked_stays_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!accept && !event_q) |=> !event_q);

    p_bad_code_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!event_q && !(mode inside {4'd8, 4'd9, 4'd10, 4'd11, 4'd12})) |=> !event_q);
endmodule

// File: rtl/gis_regs.sv
module gis_regs
    import gis_pkg::*;
#(
    parameter int NPIN = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_wr,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [NPIN-1:0]         bus_wdata,
    input  logic [NPIN-1:0]         raw_ev,
    output logic [NPIN-1:0]         accept_q,
    output logic [NPIN-1:0]         mask_q,
    output logic [NPIN*FIELD_W-1:0] sense_q,
    output logic [NPIN-1:0]         ack_vec,
    output logic [NPIN-1:0]         bus_rdata
);
    localparam int NSREG = (NPIN * FIELD_W) / NPIN;

    logic wr_accept, wr_mset, wr_mclr;

    assign wr_accept = bus_wr && (bus_addr == OFF_ACCEPT);
    assign wr_mset   = bus_wr && (bus_addr == OFF_MSET);
    assign wr_mclr   = bus_wr && (bus_addr == OFF_MCLR);
    assign ack_vec   = (bus_wr && (bus_addr == OFF_ACK)) ? bus_wdata : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            accept_q <= '0;
        end else if (wr_accept) begin
            accept_q <= bus_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (wr_mset) begin
            mask_q <= mask_q | bus_wdata;
        end else if (wr_mclr) begin
            mask_q <= mask_q & ~bus_wdata;
        end
    end

    for (genvar g = 0; g < NSREG; g++) begin : g_sense
        localparam logic [ADDR_W-1:0] SADDR = OFF_SENSE + ADDR_W'(4 * g);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sense_q[g*NPIN +: NPIN] <= '0;
            end else if (bus_wr && (bus_addr == SADDR)) begin
                sense_q[g*NPIN +: NPIN] <= bus_wdata;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFF_ACCEPT: bus_rdata = accept_q;
            OFF_MCLR:   bus_rdata = mask_q;
            OFF_RAW:    bus_rdata = raw_ev;
            OFF_MSTAT:  bus_rdata = raw_ev & mask_q;
            default:    ;
        endcase
        for (int g = 0; g < NSREG; g++) begin
            if (bus_addr == OFF_SENSE + ADDR_W'(4 * g)) begin
                bus_rdata = sense_q[g*NPIN +: NPIN];
            end
        end
    end

    p_mask_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mset |=> ((mask_q & $past(bus_wdata)) == $past(bus_wdata)));

    p_mask_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mclr |=> ((mask_q & $past(bus_wdata)) == '0));

    p_accept_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_accept |=> $stable(accept_q));
endmodule

// File: rtl/gpio_irq_sense_ctrl.sv
module gpio_irq_sense_ctrl
    import gis_pkg::*;
#(
    parameter int NPIN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPIN-1:0]   pin_in,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPIN-1:0]   bus_wdata,
    output logic [NPIN-1:0]   bus_rdata,
    output logic              irq_lo,
    output logic              irq_hi
);
    localparam int HALF = NPIN / 2;

    logic [NPIN-1:0]         accept_q;
    logic [NPIN-1:0]         mask_q;
    logic [NPIN*FIELD_W-1:0] sense_q;
    logic [NPIN-1:0]         ack_vec;
    logic [NPIN-1:0]         raw_ev;
    logic [NPIN-1:0]         pend;

    gis_regs #(.NPIN(NPIN)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .raw_ev    (raw_ev),
        .accept_q  (accept_q),
        .mask_q    (mask_q),
        .sense_q   (sense_q),
        .ack_vec   (ack_vec),
        .bus_rdata (bus_rdata)
    );

    for (genvar p = 0; p < NPIN; p++) begin : g_pin
        gis_pin_cell u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin     (pin_in[p]),
            .mode    (sense_q[p*FIELD_W +: FIELD_W]),
            .accept  (accept_q[p]),
            .ack     (ack_vec[p]),
            .event_q (raw_ev[p])
        );
    end

    assign pend   = raw_ev & mask_q;
    assign irq_lo = |pend[HALF-1:0];
    assign irq_hi = |pend[NPIN-1:HALF];

    p_irq_lo_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_lo |-> ((|raw_ev[HALF-1:0]) && (|mask_q[HALF-1:0])));

    p_irq_hi_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_hi |-> ((|raw_ev[NPIN-1:HALF]) && (|mask_q[NPIN-1:HALF])));

    p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFF_ACK && bus_wdata[0] && sense_q[FIELD_W-1:0] == 4'd0)
        |=> !raw_ev[0]);
endmodule

// File: tb/tb_gpio_irq_sense_ctrl.sv
module tb_gpio_irq_sense_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] pin_in;
    logic        bus_wr;
    logic [6:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        irq_lo, irq_hi;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_irq_sense_ctrl dut (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_lo(irq_lo), .irq_hi(irq_hi)
    );

    // {code[3:0], previous pin, next pin, expected event}
    localparam logic [6:0] VEC [18] = '{
        {4'd8,  1'b0, 1'b1, 1'b1}, {4'd8,  1'b1, 1'b0, 1'b0}, {4'd8,  1'b1, 1'b1, 1'b0},
        {4'd9,  1'b1, 1'b0, 1'b1}, {4'd9,  1'b0, 1'b1, 1'b0}, {4'd9,  1'b0, 1'b0, 1'b0},
        {4'd10, 1'b1, 1'b1, 1'b1}, {4'd10, 1'b0, 1'b0, 1'b0}, {4'd10, 1'b0, 1'b1, 1'b1},
        {4'd11, 1'b0, 1'b0, 1'b1}, {4'd11, 1'b1, 1'b1, 1'b0},
        {4'd12, 1'b0, 1'b1, 1'b1}, {4'd12, 1'b1, 1'b0, 1'b1}, {4'd12, 1'b1, 1'b1, 1'b0},
        {4'd3,  1'b0, 1'b1, 1'b0}, {4'd7,  1'b1, 1'b0, 1'b0}, {4'd13, 1'b0, 1'b1, 1'b0},
        {4'd15, 1'b1, 1'b1, 1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] r;
        string tag;
        rst_n = 1'b0; pin_in = '1; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();

        // R1 reset state
        rd(7'h14, r); chk("R1 accept", r, 32'h0);
        rd(7'h1C, r); chk("R1 mask", r, 32'h0);
        rd(7'h20, r); chk("R1 raw", r, 32'h0);
        rd(7'h24, r); chk("R1 masked", r, 32'h0);
        rd(7'h40, r); chk("R1 sense0", r, 32'h0);
        rd(7'h4C, r); chk("R1 sense3", r, 32'h0);
        chk("R1 irqs", {30'd0, irq_hi, irq_lo}, 32'h0);

        // R12 field layout readback and no false edge on held pins
        for (int i = 0; i < 4; i++) wr(7'h40 + 7'(4*i), 32'h88888888);
        wr(7'h14, 32'hFFFF_FFFF);
        rd(7'h44, r); chk("R12 sense1 readback", r, 32'h88888888);
        repeat (3) tick();
        rd(7'h20, r); chk("R12 no false edge", r, 32'h0);
        for (int i = 0; i < 4; i++) wr(7'h40 + 7'(4*i), 32'h0);
        pin_in = '0;
        tick();
        wr(7'h28, 32'hFFFF_FFFF);

        // R2/R3/R4 table on pin 3 (register 0x40 bits 15:12)
        foreach (VEC[k]) begin
            logic [3:0] m;
            m = VEC[k][6:3];
            wr(7'h40, 32'h0);
            pin_in[3] = VEC[k][2];
            tick();
            wr(7'h28, 32'hFFFF_FFFF);
            wr(7'h40, {16'h0, m, 12'h0});
            pin_in[3] = VEC[k][1];
            tick();
            rd(7'h20, r);
            if (m == 4'd8 || m == 4'd9) tag = "R2 edge code";
            else if (m == 4'd10 || m == 4'd11) tag = "R3 level code";
            else tag = "R4 both or invalid code";
            chk(tag, {31'd0, r[3]}, {31'd0, VEC[k][0]});
        end

        // R5 accept enable
        wr(7'h40, 32'h8000);
        pin_in[3] = 1'b0; tick();
        wr(7'h28, 32'hFFFF_FFFF);
        wr(7'h14, 32'hFFFF_FFF7);
        rd(7'h14, r); chk("R5 accept readback", r, 32'hFFFF_FFF7);
        pin_in[3] = 1'b1; tick();
        rd(7'h20, r); chk("R5 blocked edge", r, 32'h0);
        wr(7'h14, 32'hFFFF_FFFF);
        pin_in[3] = 1'b0; tick();
        pin_in[3] = 1'b1; tick();
        wr(7'h14, 32'h0);
        tick();
        rd(7'h20, r); chk("R5 held event kept", r, 32'h8);
        wr(7'h28, 32'h8);
        rd(7'h20, r); chk("R8 ack with accept off", r, 32'h0);
        wr(7'h14, 32'hFFFF_FFFF);
        wr(7'h40, 32'h0);

        // R6 mask set/clear
        wr(7'h18, 32'h00F0_0F00);
        rd(7'h1C, r); chk("R6 mask set", r, 32'h00F0_0F00);
        wr(7'h1C, 32'h0000_0F00);
        rd(7'h1C, r); chk("R6 mask clear", r, 32'h00F0_0000);
        wr(7'h1C, 32'hFFFF_FFFF);
        rd(7'h1C, r); chk("R6 mask all clear", r, 32'h0);

        // R7/R9 pins 2 and 20 rising
        wr(7'h40, 32'h0000_0800);
        wr(7'h48, 32'h0008_0000);
        pin_in = '0; tick();
        wr(7'h28, 32'hFFFF_FFFF);
        pin_in[2] = 1'b1; pin_in[20] = 1'b1;
        tick();
        rd(7'h20, r); chk("R7 raw", r, 32'h0010_0004);
        rd(7'h24, r); chk("R7 masked none", r, 32'h0);
        chk("R9 irqs masked off", {30'd0, irq_hi, irq_lo}, 32'h0);
        wr(7'h18, 32'h0010_0000);
        rd(7'h24, r); chk("R7 masked hi", r, 32'h0010_0000);
        chk("R9 irq_hi only", {30'd0, irq_hi, irq_lo}, 32'h2);
        wr(7'h18, 32'h0000_0004);
        chk("R9 both irqs", {30'd0, irq_hi, irq_lo}, 32'h3);

        // R8 acknowledge
        wr(7'h28, 32'h0010_0000);
        rd(7'h20, r); chk("R8 ack pin20", r, 32'h0000_0004);
        chk("R9 after ack", {30'd0, irq_hi, irq_lo}, 32'h1);
        wr(7'h28, 32'h0000_0004);
        rd(7'h20, r); chk("R8 ack pin2", r, 32'h0);
        chk("R9 idle", {30'd0, irq_hi, irq_lo}, 32'h0);

        // R10 edge and ack in the same cycle
        pin_in[2] = 1'b0; tick();
        pin_in[2] = 1'b1; tick();
        pin_in[2] = 1'b0; tick();
        rd(7'h20, r); chk("R10 pre", r, 32'h4);
        pin_in[2] = 1'b1;
        wr(7'h28, 32'h4);
        rd(7'h20, r); chk("R10 edge beats ack", r, 32'h4);
        wr(7'h28, 32'h4);
        rd(7'h20, r); chk("R10 plain ack", r, 32'h0);

        // R11 level re-set after ack
        wr(7'h48, 32'h000A_0000);
        pin_in[20] = 1'b0; tick();
        pin_in[20] = 1'b1; tick();
        rd(7'h20, r); chk("R11 level set", r, 32'h0010_0000);
        wr(7'h28, 32'h0010_0000);
        rd(7'h20, r); chk("R11 dropped after ack", r, 32'h0);
        chk("R11 irq_hi low", {31'd0, irq_hi}, 32'h0);
        tick();
        rd(7'h20, r); chk("R11 set again", r, 32'h0010_0000);
        chk("R11 irq_hi back", {31'd0, irq_hi}, 32'h1);

        finish_run();
    end
endmodule